// File: doc/BRIEF.md
# Loss-of-Signal Qualifier and Alarm-Indication Inserter

This block sits in a 2.048 Mbit/s receive path directly after the line decoder. It takes the raw loss-of-signal flag reported by an external line interface and debounces it. The flag must stay high for a parameterised number of consecutive clock cycles before the block reports a qualified loss. A control bit can bypass the debounce so that the raw flag reaches the output unchanged.

The block then decides whether to replace the two decoded data rails with an alarm indication signal (AIS). AIS is an unframed stream of ones on both rails. A two-bit mode selects one of three behaviours:
- insert AIS whenever loss is reported,
- never insert AIS,
- always insert AIS.

While AIS is being inserted, the rails can be timed either by the line bit strobe or by a strobe derived from a local 2.048 MHz reference, called the blue clock. Both clocks are brought into one system clock as bit-enable strobes. This models a glitch-free clock selection as a synchronous choice of strobe. The block reports the current AIS state and whether the blue clock is timing the output.

Top module: `los_ais_cond`

## Requirements
- R1: With the filter enabled, `los_out` rises after the clock edge at which `los_raw` has been sampled high for LOS_WINDOW (default 128) consecutive edges, and not one edge earlier.
- R2: An edge that samples `los_raw` low clears the qualified loss state and restarts the run count from zero, so `los_out` (filter enabled) is low after that edge.
- R3: With `filt_en` = 0, `los_out` equals `los_raw` in the same cycle, with no register in the path.
- R4: Mode `ais_mode` = 2'b00 (automatic) makes `ais_status` equal to `los_out`.
- R5: Mode `ais_mode` = 2'b01 (off) holds `ais_status` low whatever the loss state.
- R6: Mode `ais_mode` = 2'b10 or 2'b11 (forced) holds `ais_status` high whatever the loss state.
- R7: On an active bit strobe, `tx_pos` and `tx_neg` load 1 while `ais_status` is high and otherwise load `rx_pos` and `rx_neg`.
- R8: While `ais_status` and `blue_sel` are both high, only `blue_ce` updates the rails. In every other case only `line_ce` updates them. Without the selected strobe, the rails hold their value.
- R9: `blue_active` is high exactly when `ais_status` and `blue_sel` are both high.
- R10: While `rst_n` is low, `tx_pos`, `tx_neg` and the qualified loss state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_raw | input | 1 | Raw loss-of-signal flag from the line interface |
| filt_en | input | 1 | 1: debounce the loss flag, 0: pass it straight through |
| ais_mode | input | 2 | 00 automatic, 01 off, 1x forced |
| blue_sel | input | 1 | Time AIS data with the reference strobe |
| line_ce | input | 1 | Bit strobe recovered from the line clock |
| blue_ce | input | 1 | Bit strobe derived from the 2.048 MHz reference |
| rx_pos | input | 1 | Decoded positive rail data |
| rx_neg | input | 1 | Decoded negative rail data |
| los_out | output | 1 | Qualified (or bypassed) loss-of-signal |
| ais_status | output | 1 | AIS currently being inserted |
| blue_active | output | 1 | Rails currently timed by the reference strobe |
| tx_pos | output | 1 | Positive rail after AIS substitution |
| tx_neg | output | 1 | Negative rail after AIS substitution |

## Verification
The bench builds the block with the default LOS_WINDOW of 128. This exposes the real debounce boundary: a run of 127 high samples must not qualify, and a run of 128 must. Random loss runs of 1 to 300 cycles repeatedly cross that boundary in both directions. Mode, bypass and blue-clock selection are changed rarely, so each combination is held long enough to see a loss both declared and cleared under it.

// File: rtl/los_ais_cond.sv
module los_ais_cond #(
  parameter int unsigned LOS_WINDOW = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       los_raw,
  input  logic       filt_en,
  input  logic [1:0] ais_mode,
  input  logic       blue_sel,
  input  logic       line_ce,
  input  logic       blue_ce,
  input  logic       rx_pos,
  input  logic       rx_neg,
  output logic       los_out,
  output logic       ais_status,
  output logic       blue_active,
  output logic       tx_pos,
  output logic       tx_neg
);

  localparam int unsigned CW = (LOS_WINDOW > 1) ? $clog2(LOS_WINDOW) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOS_WINDOW - 1);

  logic [CW-1:0] run_cnt;
  logic          los_held;
  logic          bit_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      los_held <= 1'b0;
    end else if (!los_raw) begin
      run_cnt  <= '0;
      los_held <= 1'b0;
    end else if (run_cnt == LAST) begin
      los_held <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign los_out     = filt_en ? los_held : los_raw;
  assign ais_status  = ais_mode[1] | ((ais_mode == 2'b00) & los_out);
  assign blue_active = ais_status & blue_sel;
  assign bit_tick    = blue_active ? blue_ce : line_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pos <= 1'b0;
      tx_neg <= 1'b0;
    end else if (bit_tick) begin
      tx_pos <= ais_status | rx_pos;
      tx_neg <= ais_status | rx_neg;
    end
  end

endmodule

// File: rtl/los_ais_cond_chk.sv
module los_ais_cond_chk #(
  parameter int unsigned LOS_WINDOW = 128,
  parameter int unsigned CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          los_raw,
  input logic [1:0]    ais_mode,
  input logic          blue_sel,
  input logic          line_ce,
  input logic          blue_ce,
  input logic          los_held,
  input logic [CW-1:0] run_cnt,
  input logic          ais_status,
  input logic          tx_pos,
  input logic          tx_neg
);

  assert_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_held) |-> ($past(run_cnt) == CW'(LOS_WINDOW - 1)) && $past(los_raw));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !los_raw |=> !los_held && (run_cnt == '0));

  assert_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ais_mode == 2'b01) |-> !ais_status);

  assert_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ais_mode[1] |-> ais_status);

  assert_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ais_status && !blue_sel && line_ce) |=> tx_pos && tx_neg);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_ce && !blue_ce) |=> $stable(tx_pos) && $stable(tx_neg));

endmodule

bind los_ais_cond los_ais_cond_chk #(.LOS_WINDOW(LOS_WINDOW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .los_raw(los_raw), .ais_mode(ais_mode),
  .blue_sel(blue_sel), .line_ce(line_ce), .blue_ce(blue_ce),
  .los_held(los_held), .run_cnt(run_cnt), .ais_status(ais_status),
  .tx_pos(tx_pos), .tx_neg(tx_neg)
);

// File: tb/los_ais_cond_test.sv
`timescale 1ns/1ps
module los_ais_cond_test;
  localparam int unsigned WIN = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic los_raw = 1'b0, filt_en = 1'b1, blue_sel = 1'b0;
  logic [1:0] ais_mode = 2'b00;
  logic line_ce = 1'b0, blue_ce = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
  logic los_out, ais_status, blue_active, tx_pos, tx_neg;

  los_ais_cond #(.LOS_WINDOW(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .los_raw(los_raw), .filt_en(filt_en),
    .ais_mode(ais_mode), .blue_sel(blue_sel), .line_ce(line_ce),
    .blue_ce(blue_ce), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .los_out(los_out), .ais_status(ais_status), .blue_active(blue_active),
    .tx_pos(tx_pos), .tx_neg(tx_neg)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_run = 0;
  bit m_filt = 0, m_pos = 0, m_neg = 0;

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b exp %0b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit exp_los();
    return filt_en ? m_filt : los_raw;
  endfunction

  function automatic bit exp_ais();
    return ais_mode[1] || (ais_mode == 2'b00 && exp_los());
  endfunction

  task automatic edge_check();
    bit act, tk;
    @(negedge clk);
    act = exp_ais();
    tk  = (act && blue_sel) ? blue_ce : line_ce;
    if (tk) begin
      m_pos = act | rx_pos;
      m_neg = act | rx_neg;
    end
    if (los_raw) begin
      if (m_run < WIN) m_run++;
      m_filt = (m_run >= WIN);
    end else begin
      m_run  = 0;
      m_filt = 0;
    end
    chk("R7 R8 tx_pos", tx_pos, m_pos);
    chk("R7 R8 tx_neg", tx_neg, m_neg);
  endtask

  task automatic comb_check();
    #1;
    chk("R1 R2 R3 los_out", los_out, exp_los());
    chk("R4 R5 R6 ais_status", ais_status, exp_ais());
    chk("R9 blue_active", blue_active, exp_ais() && blue_sel);
  endtask

  task automatic cyc(logic l, logic f, logic [1:0] m, logic bs,
                     logic lc, logic bc, logic p, logic n);
    edge_check();
    los_raw = l; filt_en = f; ais_mode = m; blue_sel = bs;
    line_ce = lc; blue_ce = bc; rx_pos = p; rx_neg = n;
    comb_check();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int run_left;
    logic lvl, f, bs;
    logic [1:0] m;
    void'($urandom(32'd7351));

    los_raw = 1'b1; line_ce = 1'b1; rx_pos = 1'b1; rx_neg = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 tx_pos reset", tx_pos, 1'b0);
    chk("R10 tx_neg reset", tx_neg, 1'b0);
    chk("R10 los_out reset", los_out, 1'b0);
    @(negedge clk);
    los_raw = 1'b0; line_ce = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < WIN; i++) cyc(1, 1, 2'b00, 0, 1, 0, 0, 1);
    chk("R1 not declared after WIN-1 samples", los_out, 1'b0);
    cyc(1, 1, 2'b00, 0, 1, 0, 0, 1);
    chk("R1 declared after WIN samples", los_out, 1'b1);
    chk("R4 auto inserts on loss", ais_status, 1'b1);
    cyc(0, 1, 2'b00, 0, 1, 0, 0, 1);
    chk("R7 ones on both rails", tx_pos & tx_neg, 1'b1);
    cyc(0, 1, 2'b00, 0, 1, 0, 0, 1);
    chk("R2 cleared after low sample", los_out, 1'b0);
    cyc(1, 0, 2'b00, 0, 1, 0, 0, 1);
    chk("R3 bypass follows raw", los_out, 1'b1);
    cyc(1, 0, 2'b01, 0, 1, 0, 0, 0);
    chk("R5 off mode no AIS", ais_status, 1'b0);
    cyc(0, 1, 2'b10, 1, 1, 0, 0, 0);
    chk("R6 forced AIS", ais_status, 1'b1);
    chk("R9 blue active", blue_active, 1'b1);
    cyc(0, 1, 2'b10, 1, 0, 1, 0, 0);
    cyc(0, 1, 2'b00, 0, 1, 0, 1, 0);
    chk("R8 blue strobe loaded ones", tx_neg, 1'b1);

    run_left = 0; lvl = 0; f = 1; m = 2'b00; bs = 0;
    for (int i = 0; i < 60000; i++) begin
      if (run_left == 0) begin
        lvl = logic'($urandom_range(0, 1));
        run_left = $urandom_range(1, 300);
      end
      run_left--;
      if ($urandom_range(0, 699) == 0) m  = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 899) == 0) f  = logic'($urandom_range(0, 1));
      if ($urandom_range(0, 499) == 0) bs = logic'($urandom_range(0, 1));
      cyc(lvl, f, m, bs, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
          logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule